// File: doc/BRIEF.md
# Two-Channel DAC Command Interpreter for an I2C Target

This block sits behind an I2C target front end that has already turned the bus into byte events: start, address byte, data byte and stop. It decides whether a transaction is meant for this device. The device address is set by three straps, and each strap has three levels. A fixed global address is also accepted. The block then decodes a byte that carries a command and a channel selection, and applies 16-bit data words to two converter channels.

Each channel keeps an input (staging) register, an active register that drives the converter, and a power state. The converter resolution is a parameter: 16, 14 or 12 bits. Incoming words are left-justified, so the block keeps only the top bits that the resolution calls for. Only the active codes and the power states leave the block. Bit-level bus handling, acknowledge generation and the analog side belong to other blocks.

Top module: `i2c_dual_dac_ctrl`

## Requirements
- R1: After reset, both active codes are zero and both channels are powered down (`pwr_on_a` = `pwr_on_b` = 0). The input registers are also zero.
- R2: An event is sampled on a rising `clk` edge while `ev_valid` is high. `ev_kind` encodes it: 0 start, 1 address byte, 2 data byte, 3 stop. An address byte carries the 7-bit address in bits 7:1 and the read flag in bit 0. Take the strap levels (0 ground, 1 floating, 2 supply, 3 reserved) as the three base-3 digits of a number, `strap_hi` most significant, and add 4. The local address holds that 5-bit value in address bits {6,5,4,1,0} and zeros in bits 3:2. A write to this address is accepted. A reserved strap level disables the local address.
- R3: A write to address 0x73 is accepted whatever the straps are.
- R4: After a non-matching address, or an address byte with the read flag set, all data bytes are ignored until the next start.
- R5: The byte after an accepted address is the control byte: command in bits 7:4, channel in bits 3:0. Command 0x0 loads each following data word into the input register only. The active code does not change.
- R6: Command 0x1 copies the input register to the active register. This happens at the edge that samples the control byte.
- R7: Command 0x3 loads the word into both registers and powers the channel up. This happens at the edge that samples the second byte of the word (the most significant byte comes first).
- R8: Command 0x4 powers the channel down at the edge that samples the control byte. The stored codes are kept.
- R9: Channel 0x0 selects A, 0x1 selects B and 0xF selects both. Any other channel code changes nothing.
- R10: The code taken from a word is the word itself at 16 bits, the word shifted right by 2 at 14 bits, and the word shifted right by 4 at 12 bits.
- R11: Each further pair of data bytes is a new word. An unpaired byte left at a stop or start changes nothing and is dropped.
- R12: Commands other than 0x0, 0x1, 0x3 and 0x4 (0xF included) change no state.
- R13: A start at any point abandons the current transaction and waits for a new address byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| strap_hi | input | 2 | Most significant address strap level |
| strap_mid | input | 2 | Middle address strap level |
| strap_lo | input | 2 | Least significant address strap level |
| ev_valid | input | 1 | Event present this cycle |
| ev_kind | input | 2 | Event type: 0 start, 1 address, 2 data, 3 stop |
| ev_byte | input | 8 | Byte carried by address and data events |
| code_a | output | RES_BITS | Active code of channel A |
| code_b | output | RES_BITS | Active code of channel B |
| pwr_on_a | output | 1 | Channel A powered up |
| pwr_on_b | output | 1 | Channel B powered up |

## Verification
Every register and power effect lands on the same rising edge that samples the deciding event. The second data byte decides for writes and the control byte decides for update and power-down, so each result is due one edge after the byte is presented. The bench drives each event on a falling edge and removes it on the next falling edge, then compares outputs at that point. That is half a cycle after the deciding edge and before any later event. Each timing requirement is also checked one byte early, where the outputs must still hold their old values. Three instances, one for each resolution, receive identical stimulus so the shift can be checked arithmetically.

// File: rtl/i2c_dual_dac_pkg.sv
package i2c_dual_dac_pkg;

   typedef enum logic [1:0] {
      EV_START = 2'd0,
      EV_ADDR  = 2'd1,
      EV_DATA  = 2'd2,
      EV_STOP  = 2'd3
   } ev_kind_t;

   typedef enum logic [3:0] {
      OP_LOAD_IN  = 4'h0,
      OP_COMMIT   = 4'h1,
      OP_LOAD_RUN = 4'h3,
      OP_SLEEP    = 4'h4
   } op_code_t;

   localparam logic [3:0] CH_BOTH = 4'hF;
   localparam int unsigned WORD_W = 16;

   typedef struct packed {
      logic              load_in;    // input register <- word
      logic              load_run;   // active register <- word
      logic              commit;     // active register <- input register
      logic              wake;       // power up
      logic              sleep;      // power down
      logic [WORD_W-1:0] word;
   } chan_op_t;

endpackage

// File: rtl/i2c_dual_dac_addr_match.sv
module i2c_dual_dac_addr_match #(
   parameter logic [6:0] GLOBAL_ADDR = 7'h73,
   parameter int unsigned STRAP_BIAS = 4
) (
   input  logic [1:0] strap_hi,
   input  logic [1:0] strap_mid,
   input  logic [1:0] strap_lo,
   input  logic [7:0] addr_byte,
   output logic       hit
);
   localparam int unsigned SUM_W = 5;

   if (STRAP_BIAS + 26 >= 32) begin : g_bias_chk
      $error("STRAP_BIAS pushes local address beyond five bits");
   end

   logic [6:0]       addr7;
   logic             rnw;
   logic [SUM_W-1:0] strap_sum;
   logic [SUM_W-1:0] packed_addr;
   logic             straps_ok;
   logic             local_hit;

   assign addr7 = addr_byte[7:1];
   assign rnw   = addr_byte[0];

   always_comb begin
      strap_sum = SUM_W'(strap_hi) * SUM_W'(9)
                + SUM_W'(strap_mid) * SUM_W'(3)
                + SUM_W'(strap_lo)
                + SUM_W'(STRAP_BIAS);
   end

   assign straps_ok   = (strap_hi != 2'd3) && (strap_mid != 2'd3) && (strap_lo != 2'd3);
   assign packed_addr = {addr7[6:4], addr7[1:0]};
   assign local_hit   = straps_ok && (addr7[3:2] == 2'b00) && (packed_addr == strap_sum);
   assign hit         = !rnw && (local_hit || (addr7 == GLOBAL_ADDR));

endmodule

// File: rtl/i2c_dual_dac_seq.sv
module i2c_dual_dac_seq
   import i2c_dual_dac_pkg::*;
#(
   parameter int unsigned NUM_CH = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ev_valid,
   input  logic [1:0]    ev_kind,
   input  logic [7:0]    ev_byte,
   input  logic          addr_hit,
   output chan_op_t      ch_op [NUM_CH]
);
   typedef enum logic [2:0] {
      S_IDLE, S_ADDR, S_CTRL, S_DATA, S_SKIP
   } seq_state_t;

   seq_state_t state_q;
   logic [3:0] opc_q;
   logic [3:0] sel_q;
   logic [7:0] msb_q;
   logic       half_q;

   logic is_start, is_addr, is_data, is_stop;
   logic at_ctrl, at_word;

   assign is_start = ev_valid && (ev_kind == EV_START);
   assign is_addr  = ev_valid && (ev_kind == EV_ADDR);
   assign is_data  = ev_valid && (ev_kind == EV_DATA);
   assign is_stop  = ev_valid && (ev_kind == EV_STOP);
   assign at_ctrl  = is_data && (state_q == S_CTRL);
   assign at_word  = is_data && (state_q == S_DATA) && half_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= S_IDLE;
         opc_q   <= OP_LOAD_IN;
         sel_q   <= 4'h0;
         msb_q   <= 8'h00;
         half_q  <= 1'b0;
      end else if (is_start) begin
         state_q <= S_ADDR;
         half_q  <= 1'b0;
      end else if (is_stop) begin
         state_q <= S_IDLE;
         half_q  <= 1'b0;
      end else if (is_addr && state_q == S_ADDR) begin
         state_q <= addr_hit ? S_CTRL : S_SKIP;
      end else if (at_ctrl) begin
         opc_q   <= ev_byte[7:4];
         sel_q   <= ev_byte[3:0];
         half_q  <= 1'b0;
         state_q <= S_DATA;
      end else if (is_data && state_q == S_DATA) begin
         if (!half_q) begin
            msb_q  <= ev_byte;
            half_q <= 1'b1;
         end else begin
            half_q <= 1'b0;
         end
      end
   end

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      logic sel_now, sel_held;
      assign sel_now  = (ev_byte[3:0] == 4'(c)) || (ev_byte[3:0] == CH_BOTH);
      assign sel_held = (sel_q == 4'(c)) || (sel_q == CH_BOTH);

      always_comb begin
         ch_op[c].commit   = at_ctrl && sel_now && (ev_byte[7:4] == OP_COMMIT);
         ch_op[c].sleep    = at_ctrl && sel_now && (ev_byte[7:4] == OP_SLEEP);
         ch_op[c].load_in  = at_word && sel_held &&
                             ((opc_q == OP_LOAD_IN) || (opc_q == OP_LOAD_RUN));
         ch_op[c].load_run = at_word && sel_held && (opc_q == OP_LOAD_RUN);
         ch_op[c].wake     = at_word && sel_held && (opc_q == OP_LOAD_RUN);
         ch_op[c].word     = {msb_q, ev_byte};
      end
   end

endmodule

// File: rtl/i2c_dual_dac_chan.sv
module i2c_dual_dac_chan
   import i2c_dual_dac_pkg::*;
#(
   parameter int unsigned RES_BITS = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  chan_op_t            op,
   output logic [RES_BITS-1:0] run_code,
   output logic                pwr_on
);
   localparam int unsigned DROP = WORD_W - RES_BITS;

   logic [RES_BITS-1:0] code_w;
   logic [RES_BITS-1:0] stage_q;
   logic [RES_BITS-1:0] run_q;
   logic                pwr_q;

   if (DROP == 0) begin : g_full
      assign code_w = op.word;
   end else begin : g_trunc
      assign code_w = op.word[WORD_W-1 -: RES_BITS];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage_q <= '0;
         run_q   <= '0;
         pwr_q   <= 1'b0;
      end else begin
         if (op.load_in)
            stage_q <= code_w;
         if (op.load_run)
            run_q <= code_w;
         else if (op.commit)
            run_q <= stage_q;
         if (op.wake)
            pwr_q <= 1'b1;
         else if (op.sleep)
            pwr_q <= 1'b0;
      end
   end

   assign run_code = run_q;
   assign pwr_on   = pwr_q;

endmodule

// File: rtl/i2c_dual_dac_ctrl.sv
module i2c_dual_dac_ctrl
   import i2c_dual_dac_pkg::*;
#(
   parameter int unsigned RES_BITS    = 16,
   parameter logic [6:0]  GLOBAL_ADDR = 7'h73
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [1:0]          strap_hi,
   input  logic [1:0]          strap_mid,
   input  logic [1:0]          strap_lo,
   input  logic                ev_valid,
   input  logic [1:0]          ev_kind,
   input  logic [7:0]          ev_byte,
   output logic [RES_BITS-1:0] code_a,
   output logic [RES_BITS-1:0] code_b,
   output logic                pwr_on_a,
   output logic                pwr_on_b
);
   localparam int unsigned NUM_CH = 2;

   if (RES_BITS != 16 && RES_BITS != 14 && RES_BITS != 12) begin : g_res_chk
      $error("RES_BITS must be 16, 14 or 12");
   end

   logic                addr_hit;
   chan_op_t            ch_op   [NUM_CH];
   logic [RES_BITS-1:0] ch_code [NUM_CH];
   logic                ch_pwr  [NUM_CH];

   i2c_dual_dac_addr_match #(
      .GLOBAL_ADDR (GLOBAL_ADDR),
      .STRAP_BIAS  (4)
   ) u_match (
      .strap_hi  (strap_hi),
      .strap_mid (strap_mid),
      .strap_lo  (strap_lo),
      .addr_byte (ev_byte),
      .hit       (addr_hit)
   );

   i2c_dual_dac_seq #(
      .NUM_CH (NUM_CH)
   ) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .ev_valid (ev_valid),
      .ev_kind  (ev_kind),
      .ev_byte  (ev_byte),
      .addr_hit (addr_hit),
      .ch_op    (ch_op)
   );

   for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
      i2c_dual_dac_chan #(
         .RES_BITS (RES_BITS)
      ) u_chan (
         .clk      (clk),
         .rst_n    (rst_n),
         .op       (ch_op[c]),
         .run_code (ch_code[c]),
         .pwr_on   (ch_pwr[c])
      );
   end

   assign code_a   = ch_code[0];
   assign code_b   = ch_code[1];
   assign pwr_on_a = ch_pwr[0];
   assign pwr_on_b = ch_pwr[1];

endmodule

// File: rtl/i2c_dual_dac_ctrl_chk.sv
module i2c_dual_dac_ctrl_chk #(
   parameter int unsigned RES_BITS = 16
) (
   input logic                clk,
   input logic                rst_n,
   input logic                ev_valid,
   input logic [1:0]          ev_kind,
   input logic [3:0]          ev_cmd_nib,
   input logic [RES_BITS-1:0] code_a,
   input logic [RES_BITS-1:0] code_b,
   input logic                pwr_on_a,
   input logic                pwr_on_b
);
   logic data_ev;
   assign data_ev = ev_valid && (ev_kind == 2'd2);

   // R1: state right after reset release
   a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (code_a == '0 && code_b == '0 && !pwr_on_a && !pwr_on_b));

   // R6/R7: active codes move only on a sampled data byte
   a_r7_code_a_on_data: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(code_a) |-> $past(data_ev));
   a_r7_code_b_on_data: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(code_b) |-> $past(data_ev));

   // R7: power-up only on a data byte
   a_r7_wake_a_on_data: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pwr_on_a) |-> $past(data_ev));
   a_r7_wake_b_on_data: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pwr_on_b) |-> $past(data_ev));

   // R8: power-down only on a control byte carrying command 0x4
   a_r8_sleep_a_cmd: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pwr_on_a) |-> $past(data_ev && ev_cmd_nib == 4'h4));
   a_r8_sleep_b_cmd: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pwr_on_b) |-> $past(data_ev && ev_cmd_nib == 4'h4));

endmodule

bind i2c_dual_dac_ctrl i2c_dual_dac_ctrl_chk #(
   .RES_BITS (RES_BITS)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .ev_valid   (ev_valid),
   .ev_kind    (ev_kind),
   .ev_cmd_nib (ev_byte[7:4]),
   .code_a     (code_a),
   .code_b     (code_b),
   .pwr_on_a   (pwr_on_a),
   .pwr_on_b   (pwr_on_b)
);

// File: tb/test_i2c_dual_dac_ctrl.sv
module test_i2c_dual_dac_ctrl;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] strap_hi = 2'd0, strap_mid = 2'd0, strap_lo = 2'd0;
   logic       ev_valid = 1'b0;
   logic [1:0] ev_kind = 2'd0;
   logic [7:0] ev_byte = 8'd0;

   logic [15:0] c16a, c16b;
   logic [13:0] c14a, c14b;
   logic [11:0] c12a, c12b;
   logic p16a, p16b, p14a, p14b, p12a, p12b;

   int n_chk = 0;
   int n_bad = 0;

   logic [15:0] ea = 16'h0, eb = 16'h0;
   logic        pa = 1'b0, pb = 1'b0;

   always #5 clk = ~clk;

   i2c_dual_dac_ctrl #(.RES_BITS(16)) i_i2c_dual_dac_ctrl (
      .clk(clk), .rst_n(rst_n), .strap_hi(strap_hi), .strap_mid(strap_mid),
      .strap_lo(strap_lo), .ev_valid(ev_valid), .ev_kind(ev_kind), .ev_byte(ev_byte),
      .code_a(c16a), .code_b(c16b), .pwr_on_a(p16a), .pwr_on_b(p16b));

   i2c_dual_dac_ctrl #(.RES_BITS(14)) i_i2c_dual_dac_ctrl_14 (
      .clk(clk), .rst_n(rst_n), .strap_hi(strap_hi), .strap_mid(strap_mid),
      .strap_lo(strap_lo), .ev_valid(ev_valid), .ev_kind(ev_kind), .ev_byte(ev_byte),
      .code_a(c14a), .code_b(c14b), .pwr_on_a(p14a), .pwr_on_b(p14b));

   i2c_dual_dac_ctrl #(.RES_BITS(12)) i_i2c_dual_dac_ctrl_12 (
      .clk(clk), .rst_n(rst_n), .strap_hi(strap_hi), .strap_mid(strap_mid),
      .strap_lo(strap_lo), .ev_valid(ev_valid), .ev_kind(ev_kind), .ev_byte(ev_byte),
      .code_a(c12a), .code_b(c12b), .pwr_on_a(p12a), .pwr_on_b(p12b));

   task automatic send(input logic [1:0] k, input logic [7:0] b);
      @(negedge clk);
      ev_valid = 1'b1; ev_kind = k; ev_byte = b;
      @(negedge clk);
      ev_valid = 1'b0;
   endtask

   task automatic check(input string tag);
      logic ok;
      n_chk++;
      ok = (c16a == ea) && (c16b == eb) &&
           (c14a == ea[15:2]) && (c14b == eb[15:2]) &&
           (c12a == ea[15:4]) && (c12b == eb[15:4]) &&
           ({p16a, p16b, p14a, p14b, p12a, p12b} == {pa, pb, pa, pb, pa, pb});
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: got a=%h/%h/%h b=%h/%h/%h pwr=%b%b%b%b%b%b exp a=%h b=%h pwr=%b%b",
                  tag, c16a, c14a, c12a, c16b, c14b, c12b,
                  p16a, p16b, p14a, p14b, p12a, p12b, ea, eb, pa, pb);
      end
   endtask

   function automatic logic accepts(input logic [6:0] a, input int s);
      return (a == 7'h73) || (a[3:2] == 2'b00 && int'({a[6:4], a[1:0]}) == s + 4);
   endfunction

   // write-and-power-up-both transaction to address a
   task automatic wr_both(input logic [7:0] abyte, input logic [15:0] w);
      send(2'd0, 8'h00);
      send(2'd1, abyte);
      send(2'd2, 8'h3F);
      send(2'd2, w[15:8]);
      send(2'd2, w[7:0]);
      send(2'd3, 8'h00);
   endtask

   localparam logic [7:0] MY_ADDR = 8'h20; // address 0x10, write, straps 0/0/0

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin : stim
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 reset state");

      // R2/R3/R4/R10: every strap setting against every address
      for (int s = 0; s < 27; s++) begin
         strap_hi  = 2'(s / 9);
         strap_mid = 2'((s / 3) % 3);
         strap_lo  = 2'(s % 3);
         for (int a = 0; a < 128; a++) begin
            logic [15:0] w;
            logic        acc;
            w   = 16'((a * 523) ^ (s * 4099) ^ 16'h5A3C);
            acc = accepts(7'(a), s);
            wr_both({7'(a), 1'b0}, w);
            if (acc) begin
               ea = w; eb = w; pa = 1'b1; pb = 1'b1;
            end
            if (a == 'h73)     check("R3 global address R10");
            else if (acc)      check("R2 local address R10");
            else               check("R4 rejected address");
         end
      end

      // reserved strap level disables local address (R2)
      strap_hi = 2'd3; strap_mid = 2'd0; strap_lo = 2'd0;
      wr_both(8'h20, 16'hDEAD);
      check("R2 reserved strap");

      strap_hi = 2'd0; strap_mid = 2'd0; strap_lo = 2'd0;

      // R4: read flag set is ignored
      wr_both(MY_ADDR | 8'h01, 16'hBEEF);
      check("R4 read flag");

      // R5: load input only
      send(2'd0, 0); send(2'd1, MY_ADDR); send(2'd2, 8'h00);
      send(2'd2, 8'h13); send(2'd2, 8'h57);
      check("R5 input only");
      send(2'd3, 0);

      // R6: commit at control byte
      send(2'd0, 0); send(2'd1, MY_ADDR); send(2'd2, 8'h10);
      ea = 16'h1357;
      check("R6 commit timing");
      send(2'd3, 0);

      // R8: power down B at control byte, codes kept
      send(2'd0, 0); send(2'd1, MY_ADDR); send(2'd2, 8'h41);
      pb = 1'b0;
      check("R8 sleep B");
      send(2'd3, 0);

      // R7: write+wake B lands on second byte
      send(2'd0, 0); send(2'd1, MY_ADDR); send(2'd2, 8'h31);
      send(2'd2, 8'hAB);
      check("R7 first byte no effect");
      send(2'd2, 8'hCD);
      eb = 16'hABCD; pb = 1'b1;
      check("R7 second byte");
      send(2'd3, 0);

      // R9: undefined channel code
      send(2'd0, 0); send(2'd1, MY_ADDR); send(2'd2, 8'h35);
      send(2'd2, 8'h99); send(2'd2, 8'h99);
      check("R9 undefined channel");
      send(2'd3, 0);
      send(2'd0, 0); send(2'd1, MY_ADDR); send(2'd2, 8'h45);
      check("R9 undefined channel sleep");
      send(2'd3, 0);

      // R9: both channels load then commit
      send(2'd0, 0); send(2'd1, MY_ADDR); send(2'd2, 8'h0F);
      send(2'd2, 8'h24); send(2'd2, 8'h68); send(2'd3, 0);
      check("R9 both load input");
      send(2'd0, 0); send(2'd1, MY_ADDR); send(2'd2, 8'h1F);
      ea = 16'h2468; eb = 16'h2468;
      check("R9 both commit");
      send(2'd3, 0);

      // R12: undefined and no-op commands leave inputs and outputs alone
      send(2'd0, 0); send(2'd1, MY_ADDR); send(2'd2, 8'h2F);
      send(2'd2, 8'h11); send(2'd2, 8'h11); send(2'd3, 0);
      send(2'd0, 0); send(2'd1, MY_ADDR); send(2'd2, 8'hFF);
      send(2'd2, 8'h22); send(2'd2, 8'h22); send(2'd3, 0);
      check("R12 undefined commands");
      send(2'd0, 0); send(2'd1, MY_ADDR); send(2'd2, 8'h1F);
      check("R12 input registers untouched");
      send(2'd3, 0);

      // R11: several words, then an unpaired byte
      send(2'd0, 0); send(2'd1, MY_ADDR); send(2'd2, 8'h30);
      for (int k = 1; k <= 3; k++) begin
         send(2'd2, 8'(k * 17)); send(2'd2, 8'(k * 34));
         ea = {8'(k * 17), 8'(k * 34)};
         check("R11 word stream");
      end
      send(2'd2, 8'h44);
      check("R11 unpaired byte");
      send(2'd3, 0);
      send(2'd0, 0); send(2'd1, MY_ADDR); send(2'd2, 8'h30);
      send(2'd2, 8'h55); send(2'd2, 8'h66);
      ea = 16'h5566;
      check("R11 unpaired byte dropped");
      send(2'd3, 0);

      // R13: start in the middle of a word
      send(2'd0, 0); send(2'd1, MY_ADDR); send(2'd2, 8'h31); send(2'd2, 8'h77);
      send(2'd0, 0); send(2'd1, MY_ADDR); send(2'd2, 8'h30);
      send(2'd2, 8'h88); send(2'd2, 8'h99);
      ea = 16'h8899;
      check("R13 restart");
      send(2'd3, 0);

      // R4: bytes after a mismatch ignored until start
      send(2'd0, 0); send(2'd1, 8'h22); send(2'd2, 8'h3F);
      send(2'd2, 8'h01); send(2'd2, 8'h02);
      check("R4 skip data");
      send(2'd3, 0);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule